// File: doc/BRIEF.md
# Corrected-Error Location Bitmap

The block keeps a map of where single-bit corrections have happened in a word-organised memory. Each time the error-correction path reports a fixed read, it passes the bank select, the top four address bits and the 5-bit syndrome. The block joins these into a 10-bit index and sets the matching bit of a 1024 x 1 array. A set bit names a board (bank plus address range), a chip row and a failing bit lane. The stored bit only says that at least one correction happened there. It does not count how many.

Software works through a separate port. It puts an index on `sw_addr_i` and reads the stored bit on `rd_data_o` in the same cycle. It can pulse `sw_clr_i` to clear that one bit, so a polling routine can read and acknowledge entries one at a time. `any_o` shows that at least one entry is set, so an idle poll can skip the scan. `wipe_i` starts a sweep that clears one location per clock over the whole array, and `busy_o` stays high while the sweep runs. The asynchronous reset clears every location at once.

Top module: `errlog_bitmap`

## Requirements
- R1: A cycle with `log_valid_i` high sets the location at index {`log_bank_i`, `log_addr_hi_i`, `log_code_i`}, where the bank bit is index bit 9, the address bits are index bits 8:5 and the code is index bits 4:0. Code bit 0 carries syndrome bit A', so syndrome A'..E' = 1,1,1,0,0 is code 5'b00111. The new value is visible on `rd_data_o` after the next rising edge.
- R2: A correction with bank 0, address bits 4'b0001 and code 5'b00111 sets index 39 (octal 047), and no other index.
- R3: A set location keeps its 1 until it is cleared, and logging one index leaves every other location unchanged.
- R4: `rd_data_o` shows, in the same cycle and without changing the array, the bit stored at `sw_addr_i`.
- R5: A cycle with `sw_clr_i` high clears only the location at `sw_addr_i`, at the next rising edge.
- R6: When a log event and a software clear target the same index in the same cycle, the location ends at 1. When they target different indices, both take effect.
- R7: While `rst_ni` is low, every location reads 0 and `any_o` and `busy_o` are 0.
- R8: `any_o` is 1 exactly when at least one location holds 1.
- R9: A `wipe_i` pulse while idle raises `busy_o` for exactly 1024 cycles. The sweep clears location k in its (k+1)-th busy cycle, so every location that is not logged during the sweep ends at 0.
- R10: During a sweep, `wipe_i` has no effect and the sweep length does not change. A log event still sets its location, and that location stays 1 if the sweep has already passed its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all locations |
| log_valid_i | input | 1 | Correction event strobe |
| log_bank_i | input | 1 | Bank select of the corrected word |
| log_addr_hi_i | input | 4 | Top address bits of the corrected word |
| log_code_i | input | 5 | Syndrome, bit 0 = A' |
| sw_addr_i | input | 10 | Software read/clear index |
| sw_clr_i | input | 1 | Clear the location at sw_addr_i |
| rd_data_o | output | 1 | Stored bit at sw_addr_i |
| any_o | output | 1 | At least one location is set |
| wipe_i | input | 1 | Start the whole-array clear sweep |
| busy_o | output | 1 | Sweep in progress |

## Verification
Three things can try to write the same bit in one cycle: a logged correction, a software clear and the sweep clear. The bench fires a log event and a software clear at the same index in one cycle and expects the bit to read 1 afterwards. It repeats this with two different indices and expects both writes to take effect. It also logs two indices during a sweep, one just behind the sweep position and one far ahead of it. The first must survive the sweep and the second must be cleared when the sweep reaches it. A second `wipe_i` pulse in the middle of the sweep must not change the measured busy length of 1024 cycles.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int unsigned DEF_BANK_W    = 1;
  localparam int unsigned DEF_ADDR_HI_W = 4;
  localparam int unsigned DEF_CODE_W    = 5;

  typedef enum logic {
    SWEEP_IDLE = 1'b0,
    SWEEP_RUN  = 1'b1
  } sweep_st_e;
endpackage

// File: rtl/errlog_index.sv
module errlog_index #(
  parameter int unsigned BANK_W    = 1,
  parameter int unsigned ADDR_HI_W = 4,
  parameter int unsigned CODE_W    = 5,
  localparam int unsigned IDX_W    = BANK_W + ADDR_HI_W + CODE_W
) (
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [ADDR_HI_W-1:0] addr_hi_i,
  input  logic [CODE_W-1:0]    code_i,
  output logic [IDX_W-1:0]     idx_o
);
  // bank on top selects board group, address picks row, code picks bit lane
  assign idx_o = {bank_i, addr_hi_i, code_i};
endmodule

// File: rtl/errlog_sweep.sv
module errlog_sweep
  import errlog_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  sweep_st_e        st_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SWEEP_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SWEEP_IDLE: begin
          if (start_i) begin
            st_q  <= SWEEP_RUN;
            cnt_q <= '0;
          end
        end
        default: begin
          if (cnt_q == LAST) st_q <= SWEEP_IDLE;
          else               cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign busy_o = (st_q == SWEEP_RUN);
  assign idx_o  = cnt_q;

  AST_SWEEP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q == LAST) |=> !busy_o); // R9
  AST_SWEEP_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != LAST) |=> (busy_o && cnt_q == IDX_W'($past(cnt_q) + 1'b1))); // R10
  AST_SWEEP_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && cnt_q == '0)); // R9
endmodule

// File: rtl/errlog_store.sv
module errlog_store #(
  parameter int unsigned IDX_W = 10,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  input  logic             wipe_en_i,
  input  logic [IDX_W-1:0] wipe_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_o,
  output logic             any_o
);
  logic [DEPTH-1:0] bits_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_bit
    logic set_hit, kill_hit;
    assign set_hit  = set_en_i  && (set_idx_i  == IDX_W'(g));
    assign kill_hit = (clr_en_i  && (clr_idx_i  == IDX_W'(g)))
                    || (wipe_en_i && (wipe_idx_i == IDX_W'(g)));
    // set has priority over any clear source
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bits_q[g] <= 1'b0;
      else if (set_hit)  bits_q[g] <= 1'b1;
      else if (kill_hit) bits_q[g] <= 1'b0;
    end
  end

  assign rd_o  = bits_q[rd_idx_i];
  assign any_o = |bits_q;

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> bits_q[$past(set_idx_i)]); // R1
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !(set_en_i && set_idx_i == clr_idx_i)) |=> !bits_q[$past(clr_idx_i)]); // R5
  AST_WIPE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wipe_en_i && !(set_en_i && set_idx_i == wipe_idx_i)) |=> !bits_q[$past(wipe_idx_i)]); // R9
  AST_READ_NO_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_en_i && !clr_en_i && !wipe_en_i) |=> $stable(bits_q)); // R4
endmodule

// File: rtl/errlog_bitmap.sv
module errlog_bitmap
  import errlog_pkg::*;
#(
  parameter int unsigned BANK_W    = DEF_BANK_W,
  parameter int unsigned ADDR_HI_W = DEF_ADDR_HI_W,
  parameter int unsigned CODE_W    = DEF_CODE_W,
  localparam int unsigned IDX_W    = BANK_W + ADDR_HI_W + CODE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 log_valid_i,
  input  logic [BANK_W-1:0]    log_bank_i,
  input  logic [ADDR_HI_W-1:0] log_addr_hi_i,
  input  logic [CODE_W-1:0]    log_code_i,
  input  logic [IDX_W-1:0]     sw_addr_i,
  input  logic                 sw_clr_i,
  output logic                 rd_data_o,
  output logic                 any_o,
  input  logic                 wipe_i,
  output logic                 busy_o
);
  logic [IDX_W-1:0] log_idx;
  logic [IDX_W-1:0] sweep_idx;
  logic             sweep_busy;

  errlog_index #(
    .BANK_W   (BANK_W),
    .ADDR_HI_W(ADDR_HI_W),
    .CODE_W   (CODE_W)
  ) i_index (
    .bank_i   (log_bank_i),
    .addr_hi_i(log_addr_hi_i),
    .code_i   (log_code_i),
    .idx_o    (log_idx)
  );

  errlog_sweep #(.IDX_W(IDX_W)) i_sweep (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(wipe_i),
    .busy_o (sweep_busy),
    .idx_o  (sweep_idx)
  );

  errlog_store #(.IDX_W(IDX_W)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (log_valid_i),
    .set_idx_i (log_idx),
    .clr_en_i  (sw_clr_i),
    .clr_idx_i (sw_addr_i),
    .wipe_en_i (sweep_busy),
    .wipe_idx_i(sweep_idx),
    .rd_idx_i  (sw_addr_i),
    .rd_o      (rd_data_o),
    .any_o     (any_o)
  );

  assign busy_o = sweep_busy;

  AST_READ_IMPLIES_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o |-> any_o); // R8
  AST_LOG_SETS_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (log_valid_i && sw_addr_i == {log_bank_i, log_addr_hi_i, log_code_i}) |=> rd_data_o
      || $changed(sw_addr_i)); // R1
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!any_o && !busy_o)); // R7
endmodule

// File: tb/test_errlog_bitmap.sv
module test_errlog_bitmap;
  localparam time CLK_P = 20ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       log_valid_i = 1'b0;
  logic [0:0] log_bank_i = '0;
  logic [3:0] log_addr_hi_i = '0;
  logic [4:0] log_code_i = '0;
  logic [9:0] sw_addr_i = '0;
  logic       sw_clr_i = 1'b0;
  logic       wipe_i = 1'b0;
  logic       rd_data_o, any_o, busy_o;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  errlog_bitmap i_errlog_bitmap (
    .clk_i, .rst_ni, .log_valid_i, .log_bank_i, .log_addr_hi_i, .log_code_i,
    .sw_addr_i, .sw_clr_i, .rd_data_o, .any_o, .wipe_i, .busy_o
  );

  // {bank, addr_hi, code, expected index}
  localparam logic [19:0] VEC [6] = '{
    {1'b0, 4'h1, 5'h07, 10'd39},
    {1'b0, 4'h0, 5'h00, 10'd0},
    {1'b1, 4'hF, 5'h1F, 10'd1023},
    {1'b1, 4'h0, 5'h00, 10'd512},
    {1'b0, 4'hA, 5'h00, 10'd320},
    {1'b0, 4'h3, 5'h15, 10'd117}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input int idx, input int exp);
    sw_addr_i = 10'(idx);
    #1;
    chk(req, int'(rd_data_o), exp);
  endtask

  task automatic drive_log(input int idx);
    log_valid_i   = 1'b1;
    log_bank_i    = 1'(idx >> 9);
    log_addr_hi_i = 4'(idx >> 5);
    log_code_i    = 5'(idx);
  endtask

  task automatic do_log(input int idx);
    @(negedge clk_i);
    drive_log(idx);
    @(negedge clk_i);
    log_valid_i = 1'b0;
  endtask

  task automatic do_clr(input int idx);
    @(negedge clk_i);
    sw_addr_i = 10'(idx);
    sw_clr_i  = 1'b1;
    @(negedge clk_i);
    sw_clr_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    #(CLK_P * 3);
    // R7 reset state
    chk("R7 any", int'(any_o), 0);
    chk("R7 busy", int'(busy_o), 0);
    rd_chk("R7 rd", 39, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 R2 R4 R5 R8: table walk
    for (int v = 0; v < 6; v++) begin
      do_log(int'(VEC[v][19:10] == 0 ? 0 : 0) + int'({VEC[v][19], VEC[v][18:15], VEC[v][14:10]}));
      rd_chk("R1 set", int'(VEC[v][9:0]), 1);
      rd_chk("R4 neighbour", int'(VEC[v][9:0] ^ 10'd1), 0);
      chk("R8 any high", int'(any_o), 1);
      do_clr(int'(VEC[v][9:0]));
      rd_chk("R5 cleared", int'(VEC[v][9:0]), 0);
      chk("R8 any low", int'(any_o), 0);
    end

    // R2 syndrome A'..E' = 11100 -> code 00111 at bank 0, addr 0001
    @(negedge clk_i);
    log_valid_i = 1'b1; log_bank_i = 1'b0; log_addr_hi_i = 4'h1; log_code_i = 5'b00111;
    @(negedge clk_i);
    log_valid_i = 1'b0;
    rd_chk("R2 idx39", 39, 1);
    rd_chk("R2 idx38", 38, 0);
    rd_chk("R2 idx295", 295, 0);

    // R3 persistence and isolation
    do_log(40);
    repeat (5) @(negedge clk_i);
    rd_chk("R3 keep39", 39, 1);
    rd_chk("R3 keep40", 40, 1);
    do_clr(39);
    rd_chk("R3 40 after clr39", 40, 1);
    rd_chk("R5 39 gone", 39, 0);
    do_clr(40);

    // R6 same-index collision: set wins
    @(negedge clk_i);
    drive_log(77);
    sw_addr_i = 10'd77; sw_clr_i = 1'b1;
    @(negedge clk_i);
    log_valid_i = 1'b0; sw_clr_i = 1'b0;
    rd_chk("R6 set wins", 77, 1);
    // R6 different indices: both act
    @(negedge clk_i);
    drive_log(500);
    sw_addr_i = 10'd77; sw_clr_i = 1'b1;
    @(negedge clk_i);
    log_valid_i = 1'b0; sw_clr_i = 1'b0;
    rd_chk("R6 clr other", 77, 0);
    rd_chk("R6 set other", 500, 1);

    // R9 R10 sweep
    do_log(3);
    do_log(700);
    @(negedge clk_i);
    wipe_i = 1'b1;
    @(negedge clk_i);
    wipe_i = 1'b0;
    n = 0;
    while (busy_o && n < 3000) begin
      n++;
      log_valid_i = 1'b0;
      wipe_i = 1'b0;
      if (n == 2) drive_log(1000);
      if (n == 100) begin
        drive_log(5);
        wipe_i = 1'b1;
      end
      @(negedge clk_i);
    end
    log_valid_i = 1'b0;
    wipe_i = 1'b0;
    chk("R9 busy length", n, 1024);
    chk("R10 restart ignored", int'(busy_o), 0);
    rd_chk("R9 cleared 3", 3, 0);
    rd_chk("R9 cleared 700", 700, 0);
    rd_chk("R9 cleared 500", 500, 0);
    rd_chk("R9 ahead log cleared", 1000, 0);
    rd_chk("R10 behind log kept", 5, 1);
    chk("R8 any after sweep", int'(any_o), 1);

    // R7 asynchronous reset mid-run
    do_log(900);
    @(negedge clk_i);
    #3;
    rst_ni = 1'b0;
    #2;
    chk("R7 async any", int'(any_o), 0);
    rd_chk("R7 async 900", 900, 0);
    rd_chk("R7 async 5", 5, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R7 busy after", int'(busy_o), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule